// File: doc/BRIEF.md
# Burst-to-Bank Address Mapper

This block sits between a memory-mapped request port and a stacked-DRAM command scheduler. It takes one incremental burst request (start byte address, beat count minus one, direction) and splits it into one command per beat. Each command names the memory stack, the destination port inside the stack, and the bank group, bank, row and column that the beat's address selects. The beat address moves up by 32 bytes before each later beat is decoded.

A two-bit static configuration input picks one of three layouts for the memory-address bits. The first is row-bank-column with the lowest bank-group bit moved to the lowest address bit, so that consecutive beats alternate between bank groups. The second is row-column-bank, which puts the bank bits lowest. The third is bank-row-column, which puts the bank bits highest. A density parameter picks between the 4-high device (16 banks, 33-bit address) and the 8-high device (32 banks, 34-bit address). The 8-high device has one extra bank-group bit. A new request is taken only while no burst is being split. Commands leave through a valid/ready handshake.

Top module: `beat_addr_mapper`

## Requirements
- R1: Address fields for the 4-high layout (`DENSE8=0`): bit 32 is the stack (0 left, 1 right), bits 31:28 are the port, and bits 27:5 are the 23-bit memory address M. For the 8-high layout (`DENSE8=1`): bit 33 is the stack, bits 32:29 are the port, and bits 28:5 are the 24-bit M. Bits 4:0 have no effect on any command.
- R2: With `map_sel` 0 or 3 (interleaved row-bank-column), bank group bit 0 is M[0], column is M[5:1], bank group bit 1 is M[6], bank is M[8:7] and row is M[22:9]. On the 8-high device, bank group bit 2 is M[23].
- R3: With `map_sel` 1 (row-column-bank) and G bank-group bits (2 or 3), bank group is M[G-1:0], bank is M[G+1:G], column is M[G+6:G+2] and row is M[G+20:G+7].
- R4: With `map_sel` 2 (bank-row-column), column is M[4:0], row is M[18:5], bank is M[20:19] and bank group is the remaining top bits of M, starting at bit 21.
- R5: A request with length field L produces exactly L+1 commands. Beat k decodes the start address plus 32·k, wrapping at the address width. Only the final command has `cmd_last` set, and `cmd_valid` falls in the cycle after that command is taken.
- R6: `req_ready` is high exactly when no burst is in progress. A request presented while a burst is being split is not taken and does not change the commands of that burst.
- R7: While `cmd_valid` is high and `cmd_ready` is low, every command output holds its value into the next cycle.
- R8: In the interleaved map, consecutive beats of one burst carry opposite values of bank group bit 0. A two-beat burst from address 0 gives (row 0, group 0, bank 0, column 0) and then (row 0, group 1, bank 0, column 0).
- R9: `cmd_write` equals the direction of the request that started the burst, on every beat.
- R10: The first command is valid in the cycle after the request handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_sel | input | 2 | Layout select: 0/3 interleaved row-bank-column, 1 row-column-bank, 2 bank-row-column |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Mapper idle, request accepted |
| req_addr | input | 33+DENSE8 | Start byte address |
| req_len | input | 8 | Beats minus one |
| req_write | input | 1 | 1 = write burst |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command accepted |
| cmd_stack | output | 1 | Stack select |
| cmd_port | output | 4 | Destination port |
| cmd_bg | output | 2+DENSE8 | Bank group |
| cmd_bank | output | 2 | Bank within group |
| cmd_row | output | 14 | Row |
| cmd_col | output | 5 | Column |
| cmd_write | output | 1 | Direction of the burst |
| cmd_last | output | 1 | Final beat of the burst |

## Verification
A wrong beat counter shows at the ports as a burst with one command too many or too few, or as a misplaced `cmd_last`. This appears at the end of the first burst. A corrupted beat address shows as wrong row, column or bank fields on the very next command. Most such faults in the interleaved map also break the alternation of bank group bit 0 between beats. A stuck busy state shows either as `req_ready` staying low after the last command or as a second request being taken in the middle of a burst, which corrupts the following commands. The bench runs a 4-high and an 8-high instance in lockstep, so that a fault in the extra bank-group bit shows up on the first command in any map.

// File: rtl/bam_pkg.sv
// Shared constants and the layout-select encoding for the burst address mapper.
package bam_pkg;
    localparam int ROW_W    = 14;
    localparam int COL_W    = 5;
    localparam int BANK_W   = 2;
    localparam int PORT_W   = 4;
    localparam int LEN_W    = 8;
    localparam int LOW_IGN  = 5;   // byte offset bits inside one 32-byte beat
    localparam int BEAT_B   = 32;

    typedef enum logic [1:0] {
        MAP_RBC_IL = 2'd0,
        MAP_RCB    = 2'd1,
        MAP_BRC    = 2'd2,
        MAP_ALT    = 2'd3   // decoded as MAP_RBC_IL
    } map_sel_e;
endpackage

// File: rtl/bam_addr_fields.sv
// Splits a byte address into stack select, destination port and memory address.
// Assumes the 4-high layout when DENSE8=0 and the 8-high layout otherwise.
// The byte-offset bits below one beat are dropped.
module bam_addr_fields
    import bam_pkg::*;
#(
    parameter int DENSE8 = 0
) (
    input  logic [32+DENSE8:0] addr,
    output logic               stack,
    output logic [PORT_W-1:0]  port,
    output logic [22+DENSE8:0] maddr
);
    localparam int AW = 33 + DENSE8;
    localparam int MW = 23 + DENSE8;

    logic unused_low_bits;

    // Pick out the fixed fields by position.
    always_comb begin
        stack = addr[AW-1];
        port  = addr[AW-2 -: PORT_W];
        maddr = addr[LOW_IGN +: MW];
    end

    assign unused_low_bits = ^addr[LOW_IGN-1:0];
endmodule

// File: rtl/bam_bank_map.sv
// Decodes a memory address into bank group, bank, row and column under the
// selected layout. Combinational only. Assumes the layout select stays
// constant for the length of a burst.
module bam_bank_map
    import bam_pkg::*;
#(
    parameter int DENSE8 = 0
) (
    input  map_sel_e           sel,
    input  logic [22+DENSE8:0] maddr,
    output logic [1+DENSE8:0]  bg,
    output logic [BANK_W-1:0]  bank,
    output logic [ROW_W-1:0]   row,
    output logic [COL_W-1:0]   col
);
    localparam int MW  = 23 + DENSE8;
    localparam int BGW = 2 + DENSE8;
    localparam int BRC_BG_LO = COL_W + ROW_W + BANK_W;

    logic [BGW-1:0] il_bg;

    // Interleaved map: BG0 lowest, BG1 above the column, and on the 8-high
    // device the extra group bit at the top of the memory address.
    generate
        if (DENSE8 != 0) begin : g_sid
            always_comb il_bg = {maddr[MW-1], maddr[6], maddr[0]};
        end else begin : g_nosid
            always_comb il_bg = {maddr[6], maddr[0]};
        end
    endgenerate

    // Select the field positions for the chosen layout.
    always_comb begin
        case (sel)
            MAP_RCB: begin
                bg   = maddr[BGW-1:0];
                bank = maddr[BGW +: BANK_W];
                col  = maddr[BGW+BANK_W +: COL_W];
                row  = maddr[BGW+BANK_W+COL_W +: ROW_W];
            end
            MAP_BRC: begin
                col  = maddr[COL_W-1:0];
                row  = maddr[COL_W +: ROW_W];
                bank = maddr[COL_W+ROW_W +: BANK_W];
                bg   = maddr[BRC_BG_LO +: BGW];
            end
            default: begin
                bg   = il_bg;
                col  = maddr[1 +: COL_W];
                bank = maddr[7 +: BANK_W];
                row  = maddr[9 +: ROW_W];
            end
        endcase
    end
endmodule

// File: rtl/bam_burst_seq.sv
// Holds one incremental burst and steps its beat address by one beat per
// accepted command. A request is taken only while idle.
module bam_burst_seq
    import bam_pkg::*;
#(
    parameter int AW = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_write,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [AW-1:0]    beat_addr,
    output logic             beat_write,
    output logic             beat_last
);
    logic             busy;
    logic [LEN_W-1:0] left;

    // Burst state: load on request, step on each command handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            left       <= '0;
            beat_addr  <= '0;
            beat_write <= 1'b0;
        end else if (!busy) begin
            if (req_valid) begin
                busy       <= 1'b1;
                left       <= req_len;
                beat_addr  <= req_addr;
                beat_write <= req_write;
            end
        end else if (cmd_ready) begin
            if (left == '0) begin
                busy <= 1'b0;
            end else begin
                left      <= left - 1'b1;
                beat_addr <= beat_addr + AW'(BEAT_B);
            end
        end
    end

    // Handshake outputs follow the busy state.
    always_comb begin
        req_ready = !busy;
        cmd_valid = busy;
        beat_last = busy && (left == '0);
    end

    // R10
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd_valid && !req_ready));

    // R5
    last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && beat_last) |=> (!cmd_valid && req_ready));

    // R5
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !beat_last) |=>
            (cmd_valid && (beat_addr - $past(beat_addr)) == AW'(BEAT_B)));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(beat_addr) && $stable(beat_last) && $stable(beat_write)));
endmodule

// File: rtl/beat_addr_mapper.sv
// Top of the burst address mapper: splits a burst into per-beat commands
// carrying stack, port, bank group, bank, row and column. Assumes map_sel
// changes only while idle and bursts are incremental.
module beat_addr_mapper
    import bam_pkg::*;
#(
    parameter int DENSE8 = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         map_sel,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [32+DENSE8:0] req_addr,
    input  logic [7:0]         req_len,
    input  logic               req_write,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic               cmd_stack,
    output logic [3:0]         cmd_port,
    output logic [1+DENSE8:0]  cmd_bg,
    output logic [1:0]         cmd_bank,
    output logic [13:0]        cmd_row,
    output logic [4:0]         cmd_col,
    output logic               cmd_write,
    output logic               cmd_last
);
    localparam int AW = 33 + DENSE8;
    localparam int MW = 23 + DENSE8;

    logic [AW-1:0] beat_addr;
    logic [MW-1:0] maddr;
    map_sel_e      sel;

    // Cast the static layout select to its enumerated form.
    always_comb sel = map_sel_e'(map_sel);

    bam_burst_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .req_write  (req_write),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .beat_addr  (beat_addr),
        .beat_write (cmd_write),
        .beat_last  (cmd_last)
    );

    bam_addr_fields #(.DENSE8(DENSE8)) u_fields (
        .addr  (beat_addr),
        .stack (cmd_stack),
        .port  (cmd_port),
        .maddr (maddr)
    );

    bam_bank_map #(.DENSE8(DENSE8)) u_map (
        .sel   (sel),
        .maddr (maddr),
        .bg    (cmd_bg),
        .bank  (cmd_bank),
        .row   (cmd_row),
        .col   (cmd_col)
    );

    // R8
    bg_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((map_sel == 2'd0 || map_sel == 2'd3) && cmd_valid && cmd_ready && !cmd_last)
            |=> (cmd_bg[0] != $past(cmd_bg[0])));

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            ($stable(cmd_row) && $stable(cmd_col) && $stable(cmd_bg) &&
             $stable(cmd_bank) && $stable(cmd_port) && $stable(cmd_stack)));

    // R6
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !(cmd_ready && cmd_last)) |=> !req_ready);
endmodule

// File: tb/beat_addr_mapper_bench.sv
// Runs a 4-high and an 8-high mapper in lockstep and checks the commands of
// both against values computed from the requirements.
module beat_addr_mapper_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  map_sel = 2'd0;
    logic        req_valid = 1'b0;
    logic [33:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        req_write = 1'b0;
    logic        cmd_ready = 1'b0;

    logic        rdy4, val4, st4, wr4, last4;
    logic [3:0]  port4;  logic [1:0] bg4;  logic [1:0] bank4;
    logic [13:0] row4;   logic [4:0] col4;
    logic        rdy8, val8, st8, wr8, last8;
    logic [3:0]  port8;  logic [2:0] bg8;  logic [1:0] bank8;
    logic [13:0] row8;   logic [4:0] col8;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    beat_addr_mapper #(.DENSE8(0)) u_beat_addr_mapper (
        .clk(clk), .rst_n(rst_n), .map_sel(map_sel),
        .req_valid(req_valid), .req_ready(rdy4), .req_addr(req_addr[32:0]),
        .req_len(req_len), .req_write(req_write),
        .cmd_valid(val4), .cmd_ready(cmd_ready), .cmd_stack(st4), .cmd_port(port4),
        .cmd_bg(bg4), .cmd_bank(bank4), .cmd_row(row4), .cmd_col(col4),
        .cmd_write(wr4), .cmd_last(last4));

    beat_addr_mapper #(.DENSE8(1)) u_beat_addr_mapper_8h (
        .clk(clk), .rst_n(rst_n), .map_sel(map_sel),
        .req_valid(req_valid), .req_ready(rdy8), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write),
        .cmd_valid(val8), .cmd_ready(cmd_ready), .cmd_stack(st8), .cmd_port(port8),
        .cmd_bg(bg8), .cmd_bank(bank8), .cmd_row(row8), .cmd_col(col8),
        .cmd_write(wr8), .cmd_last(last8));

    // Expected command word {stack,port,bg[2:0],bank,row,col,write,last} (R1-R4, R9).
    function automatic logic [30:0] expect_cmd(logic [33:0] a, bit eh, logic [1:0] sel,
                                               bit wr, bit last);
        logic [23:0] m; logic stack; logic [3:0] port; logic [2:0] bg;
        logic [1:0] bank; logic [13:0] row; logic [4:0] col; int g;
        if (eh) begin stack = a[33]; port = a[32:29]; m = a[28:5]; g = 3; end
        else    begin stack = a[32]; port = a[31:28]; m = {1'b0, a[27:5]}; g = 2; end
        case (sel)
            2'd1: begin
                bg   = eh ? m[2:0] : {1'b0, m[1:0]};
                bank = m[g +: 2]; col = m[g+2 +: 5]; row = m[g+7 +: 14];
            end
            2'd2: begin
                col = m[4:0]; row = m[18:5]; bank = m[20:19];
                bg  = eh ? m[23:21] : {1'b0, m[22:21]};
            end
            default: begin
                bg = {eh ? m[23] : 1'b0, m[6], m[0]};
                col = m[5:1]; bank = m[8:7]; row = m[22:9];
            end
        endcase
        return {stack, port, bg, bank, row, col, wr, last};
    endfunction

    function automatic logic [30:0] got4();
        return {st4, port4, 1'b0, bg4, bank4, row4, col4, wr4, last4};
    endfunction
    function automatic logic [30:0] got8();
        return {st8, port8, bg8, bank8, row8, col8, wr8, last8};
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string map_tag(logic [1:0] sel);
        return (sel == 2'd1) ? "R3" : (sel == 2'd2) ? "R4" : "R2";
    endfunction

    // One burst on both instances; junk=1 keeps a rival request asserted (R6).
    task automatic run_burst(logic [33:0] addr, logic [7:0] len, bit wr,
                             logic [1:0] sel, bit junk);
        logic [33:0] a4, a8;
        logic [30:0] snap4, snap8;
        bit r;
        @(negedge clk);
        map_sel = sel; req_valid = 1'b1; req_addr = addr; req_len = len; req_write = wr;
        check(rdy4 && rdy8, "R6 idle ready", {rdy4, rdy8}, 2'b11);
        @(posedge clk);
        @(negedge clk);
        if (junk) begin req_addr = ~addr; req_len = 8'd3; req_write = ~wr; end
        else req_valid = 1'b0;
        // R10: first command valid one cycle after the request handshake
        check(val4 && val8, "R10 first valid", {val4, val8}, 2'b11);
        a4 = {1'b0, addr[32:0]};
        a8 = addr;
        for (int k = 0; k <= int'(len); k++) begin
            do begin
                r = ($urandom % 10) < 7;
                cmd_ready = r;
                if (!r) begin
                    snap4 = got4(); snap8 = got8();
                    @(posedge clk); @(negedge clk);
                    check(val4 && got4() == snap4, "R7 hold 4h", got4(), snap4);
                    check(val8 && got8() == snap8, "R7 hold 8h", got8(), snap8);
                end
            end while (!r);
            check(val4 && got4() == expect_cmd(a4, 0, sel, wr, k == int'(len)),
                  {map_tag(sel), " R5 R9 beat 4h"}, got4(),
                  expect_cmd(a4, 0, sel, wr, k == int'(len)));
            check(val8 && got8() == expect_cmd(a8, 1, sel, wr, k == int'(len)),
                  {map_tag(sel), " R5 R9 beat 8h"}, got8(),
                  expect_cmd(a8, 1, sel, wr, k == int'(len)));
            check(!rdy4 && !rdy8, "R6 busy not ready", {rdy4, rdy8}, 2'b00);
            @(posedge clk);
            @(negedge clk);
            a4 = {1'b0, a4[32:0] + 33'd32};
            a8 = a8 + 34'd32;
        end
        req_valid = 1'b0;
        cmd_ready = 1'b0;
        // R5: burst done, no extra command, ready again
        check(!val4 && !val8 && rdy4 && rdy8, "R5 end of burst",
              {val4, val8, rdy4, rdy8}, 4'b0011);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state
        check(!val4 && !val8 && rdy4 && rdy8, "R6 reset", {val4, val8, rdy4, rdy8}, 4'b0011);
        rst_n = 1'b1;
        @(negedge clk);
        check(!val4 && !val8, "R5 idle after reset", {val4, val8}, 2'b00);

        // R8: two-beat burst from address 0 in the interleaved map
        req_valid = 1'b1; req_addr = '0; req_len = 8'd1; req_write = 1'b0; map_sel = 2'd0;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; cmd_ready = 1'b1;
        check({row4, bg4, bank4, col4} == '0, "R8 first beat", {row4, bg4, bank4, col4}, 0);
        @(posedge clk); @(negedge clk);
        check(row4 == 0 && bg4 == 2'd1 && bank4 == 0 && col4 == 0 && last4,
              "R8 second beat", {row4, bg4, bank4, col4, last4}, {14'd0, 2'd1, 2'd0, 5'd0, 1'b1});
        @(posedge clk); @(negedge clk);
        cmd_ready = 1'b0;

        // R1: offset bits 4:0 ignored
        run_burst(34'h2_A5A5_A5BF, 8'd2, 1'b1, 2'd0, 1'b0);
        // R2: 8-high SID bit at the top of the memory address
        run_burst(34'h1_1000_0000, 8'd0, 1'b0, 2'd0, 1'b0);
        run_burst(34'h0_0FFF_FFE0, 8'd3, 1'b1, 2'd3, 1'b0);
        run_burst(34'h0_0000_0000, 8'd7, 1'b0, 2'd1, 1'b0);
        run_burst(34'h0_0000_0000, 8'd5, 1'b1, 2'd2, 1'b0);
        // R5: wrap at the top of the address space
        run_burst(34'h3_FFFF_FFC0, 8'd3, 1'b0, 2'd1, 1'b0);
        // R6: rival request held during the burst
        run_burst(34'h1_2345_6780, 8'd4, 1'b1, 2'd0, 1'b1);

        for (int i = 0; i < 60; i++) begin
            logic [33:0] a;
            logic [7:0] l;
            a = {$urandom, $urandom} & 34'h3_FFFF_FFFF;
            l = ($urandom % 8 == 0) ? 8'd15 : 8'($urandom % 8);
            run_burst(a, l, 1'($urandom), 2'($urandom), 1'($urandom % 4 == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule